// File: doc/BRIEF.md
# Colour Channel Gain/Offset Rotation Sequencer

This block decides, for every conversion clock period, which colour input (red, green or blue) is active in a scanner front end. It also picks the matching gain and offset codes out of a bank of six programmed codes. A 2-bit configuration field selects one of four schemes:

- a single red channel;
- red and green alternating pixel by pixel;
- red, green and blue rotating pixel by pixel;
- red, green and blue rotating once per scan line.

All inputs are synchronous to the system clock `clk`. The block finds falling edges of the conversion clock and of the line-sync input by comparing each of them with its value one clock earlier. Every selection output is registered.

The line-sync level has two effects. In the pixel-rate schemes it pins the pointer to red, and while it is high it releases the output data bus. In the line-rate scheme its falling edges step the line colour. A write of the mode register that selects the line-rate scheme restarts that scheme at red. The selected codes are reloaded only at defined update events. A bank rewrite part-way through a pixel therefore never reaches the gain or offset stage until the next event. There is no streaming data path, so every pin is a plain level or pulse.

Top module: `color_rot_seq`

## Requirements
- R1: While and right after reset, `chan` is red (0), `gain_sel` and `ofs_sel` are zero, and `sample_all` is low.
- R2: Channels are encoded red=0, green=1, blue=2, and `chan` never shows 3. With `cfg_mode`=00, every update selects red together with the red gain and red offset.
- R3: With `cfg_mode`=01 and `line_sync` low, each conversion-clock falling edge toggles `chan` between red and green. The new value is visible one clock after the clock in which the fall was seen.
- R4: With `cfg_mode`=10 and `line_sync` low, each conversion-clock falling edge steps `chan` through red, green, blue and back to red, one clock later.
- R5: In `cfg_mode` 00, 01 and 10, `chan` is red on the clock after any clock in which `line_sync` is high. In every scheme, `bus_oe` is low during the same clock in which `line_sync` is high, and high otherwise.
- R6: A `mode_wr` pulse with `cfg_mode`=11 sets the line colour to red and arms it. The first `line_sync` falling edge after that keeps red. Each later falling edge steps red, green, blue, red. In this scheme conversion-clock edges never move `chan`.
- R7: `gain_sel` and `ofs_sel` always equal the bank codes of the channel selected at the most recent update event. The update events are: a conversion-clock fall, a clock with `line_sync` high, a `line_sync` fall, and a `mode_wr` pulse. A bank change between events leaves both outputs unchanged.
- R8: In `cfg_mode` 01 or 10 with `line_sync` low, `sample_all` pulses high for exactly one clock when a conversion-clock fall brings `chan` to red. It is low in all other cases, including the whole of `cfg_mode` 11.
- R9: `line_sync` may rise only while `conv_clk` is high, so that a line start never meets a conversion-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_clk | input | 1 | Conversion clock level, synchronous to clk |
| line_sync | input | 1 | Line sync level, high between lines |
| cfg_mode | input | 2 | Scheme: 00 single, 01 dual, 10 triple pixel, 11 triple line |
| mode_wr | input | 1 | One-clock pulse when the mode register is written |
| gain_r | input | GAIN_W | Red gain code |
| gain_g | input | GAIN_W | Green gain code |
| gain_b | input | GAIN_W | Blue gain code |
| ofs_r | input | OFS_W | Red offset code |
| ofs_g | input | OFS_W | Green offset code |
| ofs_b | input | OFS_W | Blue offset code |
| chan | output | 2 | Active channel index |
| gain_sel | output | GAIN_W | Gain code applied to the current pixel |
| ofs_sel | output | OFS_W | Offset code applied to the current pixel |
| sample_all | output | 1 | One-clock strobe: all inputs sampled together |
| bus_oe | output | 1 | Data bus output enable, low during line sync |

## Verification
A corrupted pointer shows at `chan` one clock after the next conversion-clock fall, and then again through `gain_sel` and `ofs_sel`, which would carry another channel's codes. A lost arm flag in the line-rate scheme shifts the whole colour sequence by one line, and this shows at the first sync fall after a mode write. A misplaced strobe shows as `sample_all` arriving on a green or blue step, or lasting two clocks. Sweeping every scheme over several full rotations exposes each of these within three conversion periods.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_e;

  localparam logic [1:0] M_SINGLE = 2'b00;
  localparam logic [1:0] M_DUAL   = 2'b01;
  localparam logic [1:0] M_TRIPLE = 2'b10;
  localparam logic [1:0] M_LINE   = 2'b11;

  localparam int NUM_CH = 3;

  function automatic chan_e rot3(chan_e c);
    case (c)
      CH_RED:  return CH_GRN;
      CH_GRN:  return CH_BLU;
      default: return CH_RED;
    endcase
  endfunction

  function automatic chan_e rot2(chan_e c);
    return (c == CH_RED) ? CH_GRN : CH_RED;
  endfunction
endpackage

// File: rtl/seq_edge.sv
module seq_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign fall[i] = prev_q[i] & ~sig[i];
  end
endmodule

// File: rtl/seq_pointer.sv
module seq_pointer
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       mode_wr,
  input  logic       sync_lvl,
  input  logic       conv_fall,
  input  logic       sync_fall,
  output chan_e      ptr_next,
  output logic       upd,
  output chan_e      ptr,
  output logic       sample_all
);
  chan_e lptr, lptr_n;
  logic  armed, armed_n;
  logic  pix_mode;

  assign pix_mode = (cfg_mode == M_DUAL) || (cfg_mode == M_TRIPLE);
  assign upd      = conv_fall | sync_lvl | sync_fall | mode_wr;

  // line colour pointer for the line-rate scheme
  always_comb begin
    lptr_n  = lptr;
    armed_n = armed;
    if (mode_wr && cfg_mode == M_LINE) begin
      lptr_n  = CH_RED;
      armed_n = 1'b1;
    end else if (sync_fall && cfg_mode == M_LINE) begin
      if (armed) armed_n = 1'b0;
      else       lptr_n  = rot3(lptr);
    end
  end

  // next channel pointer, applied only on an update event
  always_comb begin
    ptr_next = ptr;
    case (cfg_mode)
      M_SINGLE: ptr_next = CH_RED;
      M_DUAL: begin
        if (sync_lvl)       ptr_next = CH_RED;
        else if (conv_fall) ptr_next = rot2(ptr);
      end
      M_TRIPLE: begin
        if (sync_lvl)       ptr_next = CH_RED;
        else if (conv_fall) ptr_next = rot3(ptr);
      end
      default: ptr_next = lptr_n;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= CH_RED;
      lptr       <= CH_RED;
      armed      <= 1'b1;
      sample_all <= 1'b0;
    end else begin
      lptr  <= lptr_n;
      armed <= armed_n;
      if (upd) ptr <= ptr_next;
      sample_all <= conv_fall & ~sync_lvl & pix_mode & (ptr_next == CH_RED);
    end
  end
endmodule

// File: rtl/seq_codes.sv
module seq_codes
  import seq_pkg::*;
#(
  parameter int GAIN_W = 6,
  parameter int OFS_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  chan_e                    sel,
  input  logic [NUM_CH*GAIN_W-1:0] gains,
  input  logic [NUM_CH*OFS_W-1:0]  offs,
  output logic [GAIN_W-1:0]        gain_q,
  output logic [OFS_W-1:0]         ofs_q
);
  logic [GAIN_W-1:0] g_arr [NUM_CH];
  logic [OFS_W-1:0]  o_arr [NUM_CH];
  logic [GAIN_W-1:0] g_pick;
  logic [OFS_W-1:0]  o_pick;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    assign g_arr[i] = gains[i*GAIN_W +: GAIN_W];
    assign o_arr[i] = offs[i*OFS_W +: OFS_W];
  end

  always_comb begin
    case (sel)
      CH_GRN: begin g_pick = g_arr[1]; o_pick = o_arr[1]; end
      CH_BLU: begin g_pick = g_arr[2]; o_pick = o_arr[2]; end
      default: begin g_pick = g_arr[0]; o_pick = o_arr[0]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      ofs_q  <= '0;
    end else if (load) begin
      gain_q <= g_pick;
      ofs_q  <= o_pick;
    end
  end
endmodule

// File: rtl/color_rot_seq.sv
module color_rot_seq
  import seq_pkg::*;
#(
  parameter int GAIN_W = 6,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_clk,
  input  logic              line_sync,
  input  logic [1:0]        cfg_mode,
  input  logic              mode_wr,
  input  logic [GAIN_W-1:0] gain_r,
  input  logic [GAIN_W-1:0] gain_g,
  input  logic [GAIN_W-1:0] gain_b,
  input  logic [OFS_W-1:0]  ofs_r,
  input  logic [OFS_W-1:0]  ofs_g,
  input  logic [OFS_W-1:0]  ofs_b,
  output logic [1:0]        chan,
  output logic [GAIN_W-1:0] gain_sel,
  output logic [OFS_W-1:0]  ofs_sel,
  output logic              sample_all,
  output logic              bus_oe
);
  logic [1:0] falls;
  chan_e      ptr, ptr_next;
  logic       upd;

  seq_edge #(.WIDTH(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({line_sync, conv_clk}),
    .fall (falls)
  );

  seq_pointer u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .mode_wr   (mode_wr),
    .sync_lvl  (line_sync),
    .conv_fall (falls[0]),
    .sync_fall (falls[1]),
    .ptr_next  (ptr_next),
    .upd       (upd),
    .ptr       (ptr),
    .sample_all(sample_all)
  );

  seq_codes #(.GAIN_W(GAIN_W), .OFS_W(OFS_W)) u_codes (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (upd),
    .sel   (ptr_next),
    .gains ({gain_b, gain_g, gain_r}),
    .offs  ({ofs_b, ofs_g, ofs_r}),
    .gain_q(gain_sel),
    .ofs_q (ofs_sel)
  );

  assign chan   = ptr;
  assign bus_oe = ~line_sync;
endmodule

// File: rtl/color_rot_seq_chk.sv
module color_rot_seq_chk #(
  parameter int GAIN_W = 6,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_clk,
  input logic              line_sync,
  input logic [1:0]        cfg_mode,
  input logic              mode_wr,
  input logic [1:0]        chan,
  input logic [GAIN_W-1:0] gain_sel,
  input logic [OFS_W-1:0]  ofs_sel,
  input logic              sample_all
);
  a_r2_chan_legal: assert property (@(posedge clk) disable iff (!rst_n)
    chan != 2'd3);

  a_r2_single_red: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_clk) && cfg_mode == 2'b00) |=> chan == 2'd0);

  a_r3_dual_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_clk) && !line_sync && cfg_mode == 2'b01 && chan == 2'd0) |=> chan == 2'd1);

  a_r4_triple_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_clk) && !line_sync && cfg_mode == 2'b10 && chan == 2'd1) |=> chan == 2'd2);

  a_r5_sync_red: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync && cfg_mode != 2'b11) |=> chan == 2'd0);

  a_r7_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(conv_clk) && !line_sync && !$fell(line_sync) && !mode_wr)
      |=> ($stable(gain_sel) && $stable(ofs_sel)));

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_all |=> !sample_all);

  a_r8_strobe_red: assert property (@(posedge clk) disable iff (!rst_n)
    sample_all |-> chan == 2'd0);

  a_r9_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_sync) |-> conv_clk);
endmodule

bind color_rot_seq color_rot_seq_chk #(.GAIN_W(GAIN_W), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_clk  (conv_clk),
  .line_sync (line_sync),
  .cfg_mode  (cfg_mode),
  .mode_wr   (mode_wr),
  .chan      (chan),
  .gain_sel  (gain_sel),
  .ofs_sel   (ofs_sel),
  .sample_all(sample_all)
);

// File: tb/tb_color_rot_seq.sv
`timescale 1ns/1ps
module tb_color_rot_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_clk = 1'b0;
  logic       line_sync = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       mode_wr = 1'b0;
  logic [5:0] gain_r = 6'd5, gain_g = 6'd23, gain_b = 6'd41;
  logic [7:0] ofs_r = 8'h40, ofs_g = 8'h91, ofs_b = 8'hE7;
  logic [1:0] chan;
  logic [5:0] gain_sel;
  logic [7:0] ofs_sel;
  logic       sample_all, bus_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  color_rot_seq dut (
    .clk(clk), .rst_n(rst_n), .conv_clk(conv_clk), .line_sync(line_sync),
    .cfg_mode(cfg_mode), .mode_wr(mode_wr),
    .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
    .ofs_r(ofs_r), .ofs_g(ofs_g), .ofs_b(ofs_b),
    .chan(chan), .gain_sel(gain_sel), .ofs_sel(ofs_sel),
    .sample_all(sample_all), .bus_oe(bus_oe)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_gain(int c);
    return (c == 0) ? int'(gain_r) : (c == 1) ? int'(gain_g) : int'(gain_b);
  endfunction

  function automatic int exp_ofs(int c);
    return (c == 0) ? int'(ofs_r) : (c == 1) ? int'(ofs_g) : int'(ofs_b);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // one conversion period; returns sampled just after the fall took effect
  task automatic conv_fall();
    conv_clk = 1'b1; step();
    conv_clk = 1'b0; step();
  endtask

  // sync pulse, rising only while conv_clk is high (R9)
  task automatic sync_pulse();
    conv_clk = 1'b1; step();
    line_sync = 1'b1; step();
    line_sync = 1'b0; step();
  endtask

  task automatic chk_sel(string tag, int c);
    chk({tag, " chan"}, int'(chan), c);
    chk({tag, " gain"}, int'(gain_sel), exp_gain(c));
    chk({tag, " ofs"}, int'(ofs_sel), exp_ofs(c));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1: reset state
    chk("R1 chan", int'(chan), 0);
    chk("R1 gain", int'(gain_sel), 0);
    chk("R1 ofs", int'(ofs_sel), 0);
    chk("R1 strobe", int'(sample_all), 0);
    rst_n = 1'b1; step();
    chk("R1 post-reset gain", int'(gain_sel), 0);

    // R5: sync high forces red and releases the bus
    conv_clk = 1'b1; step();
    line_sync = 1'b1;
    #1 chk("R5 bus_oe low", int'(bus_oe), 0);
    step();
    chk_sel("R5 R7 sync red", 0);
    line_sync = 1'b0;
    #1 chk("R5 bus_oe high", int'(bus_oe), 1);
    step();

    // R2: single channel
    for (int k = 1; k <= 3; k++) begin
      conv_fall();
      chk_sel("R2 single", 0);
    end

    // R3: dual, R8 strobe
    cfg_mode = 2'b01; sync_pulse();
    for (int k = 1; k <= 6; k++) begin
      conv_fall();
      chk_sel("R3 dual", k % 2);
      chk("R8 dual strobe", int'(sample_all), (k % 2 == 0) ? 1 : 0);
    end
    step();
    chk("R8 strobe one clock", int'(sample_all), 0);

    // R4: triple pixel, R8 strobe
    cfg_mode = 2'b10; sync_pulse();
    for (int k = 1; k <= 9; k++) begin
      conv_fall();
      chk_sel("R4 triple", k % 3);
      chk("R8 triple strobe", int'(sample_all), (k % 3 == 0) ? 1 : 0);
    end
    step();
    chk("R8 strobe one clock", int'(sample_all), 0);

    // R5: sync mid-rotation from green
    conv_fall();
    chk("R4 at green", int'(chan), 1);
    sync_pulse();
    chk_sel("R5 sync resets to red", 0);

    // R7: mid-pixel bank change is not seen until the next event
    conv_fall();
    chk_sel("R7 green", 1);
    conv_clk = 1'b1; step();
    gain_g = 6'd33; ofs_g = 8'h2C;
    step(); step();
    chk("R7 gain held", int'(gain_sel), 23);
    chk("R7 ofs held", int'(ofs_sel), 145);
    conv_fall(); chk_sel("R7 blue", 2);
    conv_fall(); chk_sel("R7 red", 0);
    conv_fall(); chk_sel("R7 new green", 1);

    // R6: line-by-line
    cfg_mode = 2'b11; mode_wr = 1'b1; step(); mode_wr = 1'b0;
    chk_sel("R6 write to red", 0);
    sync_pulse();
    chk("R6 armed first line red", int'(chan), 0);
    for (int ln = 1; ln <= 4; ln++) begin
      for (int k = 0; k < 4; k++) begin
        conv_fall();
        chk_sel("R6 line steady", (ln - 1) % 3);
        chk("R8 no strobe in line mode", int'(sample_all), 0);
      end
      sync_pulse();
      chk_sel("R6 line step", ln % 3);
    end
    // rewrite while on green restarts at red
    mode_wr = 1'b1; step(); mode_wr = 1'b0;
    chk_sel("R6 rewrite red", 0);
    sync_pulse();
    chk("R6 rewrite armed", int'(chan), 0);
    sync_pulse();
    chk("R6 then green", int'(chan), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule